// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block converts asynchronous bytes into the short infrared pulses used by serial-rate infrared links, and decodes such pulses back into bytes. A byte handed to the transmitter goes out as ten bit slots: a start slot, eight data slots with the least significant bit first, and a stop slot. Every slot that carries a zero is marked by one pulse at the start of the slot. A slot that carries a one stays dark. The receiver finds the start pulse and tracks the slot grid from there. It rebuilds the byte and reports a framing error when light appears in the stop slot.

Timing comes from a 16-bit configuration word. It holds a rate divisor, a pulse-width code and a preamble count. One slot lasts `BASE_CLKS * (divisor + 1)` clocks. `BASE_CLKS` is the number of clocks in one bit at 115200 bit/s, which is 416 for a 48 MHz clock. The pulse lasts `pulse code * PULSE_UNIT` clocks. Separate controls invert the transmit output and the receive input, to suit emitters and detectors that are active low. Two registered status flags report whether the word is usable. While the word is unusable, both directions are held idle.

Top module: `sirPulseCodec`

## Requirements
- R1: The configuration word holds the rate divisor in bits 15:10, the pulse-width code in bits 9:5 and the preamble count in bits 4:0. Divisor values 0, 1, 2, 5 and 11 are supported, and with each of them one bit slot lasts `BASE_CLKS * (divisor + 1)` clocks.
- R2: Each transmitted zero bit produces one active pulse. The pulse starts on the first clock of the slot and lasts `pulse code * PULSE_UNIT` clocks.
- R3: A byte is accepted on a clock edge where `txValid` and `txReady` are both high. The output slots start on the next cycle, in this order: start bit (0), data bits 0 to 7, stop bit (1). One bits produce no pulse. `txReady` returns high exactly `10 * slot` cycles after acceptance.
- R4: The transmit output equals the pulse level XOR `invTx`. This includes idle, where the output equals `invTx`.
- R5: The receiver decodes a pulse train that follows the R3 framing. It presents the byte on `rxData` together with a `rxValid` pulse that lasts exactly one cycle.
- R6: With `invRx` high, the receiver treats a low level on `irRx` as light.
- R7: A pulse inside the stop slot sets `rxErr` together with `rxValid`. The byte is still delivered, and the next frame decodes normally.
- R8: `cfgValid` and `cfgError` are registered, both low during reset, and update one cycle after the word changes. `cfgError` is high when the divisor is unsupported, when the pulse code is 0, or when the pulse length is not shorter than one slot. `cfgValid` is high otherwise.
- R9: While `cfgError` is high, `txReady` stays low, the transmit output stays idle, and the receiver produces no bytes.
- R10: The preamble count field has no effect on the transmitted waveform.
- R11: During reset, the transmit output is idle, `txReady` is low and `rxValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Physical-layer clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWord | input | 16 | Rate divisor, pulse-width code and preamble count |
| invTx | input | 1 | Invert the transmit output |
| invRx | input | 1 | Invert the receive input |
| txValid | input | 1 | A byte is offered for transmission |
| txData | input | 8 | Byte to transmit |
| txReady | output | 1 | Transmitter idle and configuration usable |
| irTx | output | 1 | Pulse output to the emitter |
| irRx | input | 1 | Pulse input from the detector, asynchronous |
| rxValid | output | 1 | One-cycle strobe: a received byte is on `rxData` |
| rxData | output | 8 | Received byte |
| rxErr | output | 1 | The byte on `rxData` had a pulse in its stop slot |
| cfgValid | output | 1 | The configuration word is usable |
| cfgError | output | 1 | The configuration word is unusable |

## Verification
The transmit waveform is due on the first cycle after the accepting edge. The bench compares the output level on every cycle of the ten slots against a model built from the divisor and pulse code. It then expects `txReady` on cycle `10 * slot`. Received bytes appear about half a slot after the stop slot begins, plus the input synchronizer delay. For that reason the receive checks pop expected bytes from a queue whenever `rxValid` rises, and do not wait for a fixed cycle. The status flags are checked two cycles after each configuration change, which leaves room for their one-cycle register.

// File: rtl/sirPcPkg.sv
package sirPcPkg;
  localparam int FRAME_BITS = 10;  // start + 8 data + stop
  localparam int DATA_BITS  = 8;

  // strobes from control to datapath
  typedef struct packed {
    logic txLoad;      // capture a new byte
    logic txShift;     // advance to next slot
    logic txWin;       // inside the pulse window of the current slot
    logic rxMidStart;  // middle of start slot
    logic rxMidData;   // middle of a data slot
    logic rxMidStop;   // middle of stop slot
  } sirStrobe_t;
endpackage

// File: rtl/sirPcCtrl.sv
module sirPcCtrl import sirPcPkg::*; #(
  parameter int BASE_CLKS  = 416,
  parameter int PULSE_UNIT = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cfgWord,
  input  logic        txValid,
  input  logic        rxEdge,
  output logic        txReady,
  output logic        cfgValid,
  output logic        cfgError,
  output sirStrobe_t  strobe
);
  localparam int TW = $clog2(BASE_CLKS * 64 + PULSE_UNIT * 32 + 1);
  localparam int IW = $clog2(FRAME_BITS);
  localparam logic [IW-1:0] LAST_IDX = IW'(FRAME_BITS - 1);

  logic [5:0]    divCode;
  logic [4:0]    pwCode;
  logic [TW-1:0] periodC, pulseC, periodR, pulseR, halfR;
  logic          divOk, errC, okR, errR;

  assign divCode = cfgWord[15:10];
  assign pwCode  = cfgWord[9:5];

  always_comb begin
    divOk   = (divCode == 6'd0) || (divCode == 6'd1) || (divCode == 6'd2) ||
              (divCode == 6'd5) || (divCode == 6'd11);
    periodC = TW'(BASE_CLKS) * (TW'(divCode) + TW'(1));
    pulseC  = TW'(PULSE_UNIT) * TW'(pwCode);
    errC    = !divOk || (pwCode == 5'd0) || (pulseC >= periodC);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      okR <= 1'b0; errR <= 1'b0;
      periodR <= '0; pulseR <= '0; halfR <= '0;
    end else begin
      okR <= !errC; errR <= errC;
      periodR <= periodC; pulseR <= pulseC; halfR <= periodC >> 1;
    end
  end

  assign cfgValid = okR;
  assign cfgError = errR;

  // transmit slot timing
  logic          txActive, txEnd;
  logic [TW-1:0] txTmr;
  logic [IW-1:0] txIdx;

  assign txEnd   = (txTmr == periodR - TW'(1));
  assign txReady = okR & ~txActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txActive <= 1'b0; txTmr <= '0; txIdx <= '0;
    end else if (!okR) begin
      txActive <= 1'b0;
    end else if (txValid && txReady) begin
      txActive <= 1'b1; txTmr <= '0; txIdx <= '0;
    end else if (txActive) begin
      if (txEnd) begin
        txTmr <= '0;
        if (txIdx == LAST_IDX) txActive <= 1'b0;
        else                   txIdx <= txIdx + IW'(1);
      end else begin
        txTmr <= txTmr + TW'(1);
      end
    end
  end

  // receive slot timing, aligned on the start pulse edge
  logic          rxActive, rxMid;
  logic [TW-1:0] rxTmr;
  logic [IW-1:0] rxIdx;

  assign rxMid = rxActive & (rxTmr == halfR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxActive <= 1'b0; rxTmr <= '0; rxIdx <= '0;
    end else if (!okR) begin
      rxActive <= 1'b0;
    end else if (!rxActive) begin
      if (rxEdge) begin
        rxActive <= 1'b1; rxTmr <= '0; rxIdx <= '0;
      end
    end else if (rxMid && rxIdx == LAST_IDX) begin
      rxActive <= 1'b0;
    end else if (rxTmr == periodR - TW'(1)) begin
      rxTmr <= '0; rxIdx <= rxIdx + IW'(1);
    end else begin
      rxTmr <= rxTmr + TW'(1);
    end
  end

  always_comb begin
    strobe.txLoad     = txValid & txReady;
    strobe.txShift    = txActive & txEnd;
    strobe.txWin      = txActive & (txTmr < pulseR);
    strobe.rxMidStart = rxMid & (rxIdx == '0);
    strobe.rxMidData  = rxMid & (rxIdx != '0) & (rxIdx != LAST_IDX);
    strobe.rxMidStop  = rxMid & (rxIdx == LAST_IDX);
  end
endmodule

// File: rtl/sirPcDatapath.sv
module sirPcDatapath import sirPcPkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sirStrobe_t           strobe,
  input  logic [DATA_BITS-1:0] txData,
  input  logic                 invTx,
  input  logic                 invRx,
  input  logic                 irRx,
  output logic                 irTx,
  output logic                 rxEdge,
  output logic                 rxValid,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxErr
);
  // transmit shift register, LSB is the current slot
  logic [FRAME_BITS-1:0] txSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                txSh <= '1;
    else if (strobe.txLoad)   txSh <= {1'b1, txData, 1'b0};
    else if (strobe.txShift)  txSh <= {1'b1, txSh[FRAME_BITS-1:1]};
  end

  assign irTx = invTx ^ (strobe.txWin & ~txSh[0]);

  // receive: synchronize, detect light onset, latch it per slot
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ, seen;
  logic [DATA_BITS-1:0]   rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0; prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], irRx ^ invRx};
      prevQ <= syncQ[SYNC_STAGES-1];
    end
  end

  assign rxEdge = syncQ[SYNC_STAGES-1] & ~prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen <= 1'b0; rxSh <= '0;
      rxValid <= 1'b0; rxData <= '0; rxErr <= 1'b0;
    end else begin
      seen <= rxEdge |
              (seen & ~(strobe.rxMidStart | strobe.rxMidData | strobe.rxMidStop));
      if (strobe.rxMidData) rxSh <= {~seen, rxSh[DATA_BITS-1:1]};
      rxValid <= strobe.rxMidStop;
      if (strobe.rxMidStop) begin
        rxData <= rxSh;
        rxErr  <= seen;
      end
    end
  end
endmodule

// File: rtl/sirPulseCodec.sv
module sirPulseCodec import sirPcPkg::*; #(
  parameter int BASE_CLKS   = 416,
  parameter int PULSE_UNIT  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cfgWord,
  input  logic        invTx,
  input  logic        invRx,
  input  logic        txValid,
  input  logic [7:0]  txData,
  output logic        txReady,
  output logic        irTx,
  input  logic        irRx,
  output logic        rxValid,
  output logic [7:0]  rxData,
  output logic        rxErr,
  output logic        cfgValid,
  output logic        cfgError
);
  sirStrobe_t strobe;
  logic       rxEdge;

  sirPcCtrl #(.BASE_CLKS(BASE_CLKS), .PULSE_UNIT(PULSE_UNIT)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .txValid(txValid),
    .rxEdge(rxEdge), .txReady(txReady), .cfgValid(cfgValid),
    .cfgError(cfgError), .strobe(strobe)
  );

  sirPcDatapath #(.SYNC_STAGES(SYNC_STAGES)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txData(txData),
    .invTx(invTx), .invRx(invRx), .irRx(irRx), .irTx(irTx),
    .rxEdge(rxEdge), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr)
  );
endmodule

// File: rtl/sirPcChecker.sv
module sirPcChecker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic irTx,
  input logic invTx,
  input logic rxValid,
  input logic cfgError
);
  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> (irTx == invTx));

  // R5
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R9
  cfg_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> !txReady);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady);
endmodule

bind sirPulseCodec sirPcChecker uChk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .irTx(irTx), .invTx(invTx), .rxValid(rxValid), .cfgError(cfgError)
);

// File: tb/tb_sirPulseCodec.sv
module tb_sirPulseCodec;
  localparam int BASE = 20;
  localparam int UNIT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] cfgWord;
  logic invTx, invRx, txValid, txReady, irTx, irRx, rxValid, rxErr;
  logic cfgValid, cfgError, loopEn, manualRx;
  logic [7:0] txData, rxData;

  assign irRx = loopEn ? irTx : manualRx;

  sirPulseCodec #(.BASE_CLKS(BASE), .PULSE_UNIT(UNIT), .SYNC_STAGES(2)) dut (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .invTx(invTx), .invRx(invRx),
    .txValid(txValid), .txData(txData), .txReady(txReady), .irTx(irTx),
    .irRx(irRx), .rxValid(rxValid), .rxData(rxData), .rxErr(rxErr),
    .cfgValid(cfgValid), .cfgError(cfgError)
  );

  typedef struct { logic [7:0] data; int period; int pulse; logic inv; string tag; } txItem_t;
  typedef struct { logic [7:0] data; logic err; } rxItem_t;
  txItem_t txQ[$];
  rxItem_t rxQ[$];

  int errors = 0, checks = 0;
  int curBr = 0, curPw = 3;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic frameBit(logic [7:0] d, int slot);
    if (slot == 0) return 1'b0;
    if (slot == 9) return 1'b1;
    return d[slot-1];
  endfunction

  task automatic drain();
    for (int n = 0; n < 20000; n++) begin
      if (txQ.size() == 0 && rxQ.size() == 0 && (txReady || !cfgValid)) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic setCfg(int br, int pw, int pre);
    drain();
    @(negedge clk);
    cfgWord = {br[5:0], pw[4:0], pre[4:0]};
    curBr = br; curPw = pw;
    repeat (2) @(negedge clk);
  endtask

  // driver: offers a byte, records the expected waveform and loopback byte
  task automatic sendByte(logic [7:0] d, string tag);
    txItem_t it;
    rxItem_t rv;
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txValid = 1'b1; txData = d;
    @(posedge clk);
    it.data = d; it.period = BASE * (curBr + 1); it.pulse = curPw * UNIT;
    it.inv = invTx; it.tag = tag;
    txQ.push_back(it);
    if (loopEn) begin rv.data = d; rv.err = 1'b0; rxQ.push_back(rv); end
    @(negedge clk);
    txValid = 1'b0;
  endtask

  // drives a pulse train straight onto irRx
  task automatic sendManual(logic [7:0] d, bit badStop, bit expectIt);
    rxItem_t rv;
    int p, pl;
    p = BASE * (curBr + 1); pl = curPw * UNIT;
    if (expectIt) begin rv.data = d; rv.err = badStop; rxQ.push_back(rv); end
    for (int b = 0; b < 10; b++) begin
      for (int c = 0; c < p; c++) begin
        @(negedge clk);
        manualRx = invRx ^ (((!frameBit(d, b)) || (b == 9 && badStop)) && c < pl);
      end
    end
    @(negedge clk);
    manualRx = invRx;
    repeat (p) @(negedge clk);
  endtask

  // monitor: transmit waveform, every cycle from the one after acceptance
  initial begin
    txItem_t it;
    int bad, badK, badAct, badExp;
    logic expv;
    forever begin
      @(negedge clk);
      if (txQ.size() != 0) begin
        it = txQ.pop_front();
        bad = 0; badK = -1; badAct = 0; badExp = 0;
        for (int k = 0; k < 10 * it.period; k++) begin
          if (k != 0) @(negedge clk);
          expv = it.inv ^ ((!frameBit(it.data, k / it.period)) && ((k % it.period) < it.pulse));
          if (irTx !== expv && bad == 0) begin
            bad = 1; badK = k; badAct = int'(irTx); badExp = int'(expv);
          end
        end
        check(bad == 0, it.tag, $sformatf("tx waveform byte %0h cycle %0d", it.data, badK), badAct, badExp);
        @(negedge clk);
        check(txReady == 1'b1, "R3", "ready after ten slots", int'(txReady), 1);
      end
    end
  end

  // monitor: received bytes against the expected queue
  always @(negedge clk) begin
    if (rxValid === 1'b1) begin
      if (rxQ.size() == 0) begin
        check(1'b0, "R5 R9", "unexpected received byte", int'(rxData), 0);
      end else begin
        rxItem_t e;
        e = rxQ.pop_front();
        check(rxData == e.data, "R5 R6", "received byte", int'(rxData), int'(e.data));
        check(rxErr == e.err, "R7", "stop slot error flag", int'(rxErr), int'(e.err));
      end
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    int bad;
    cfgWord = {6'd0, 5'd3, 5'd0};
    invTx = 1'b0; invRx = 1'b0; txValid = 1'b0; txData = 8'h00;
    loopEn = 1'b1; manualRx = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(irTx == 1'b0, "R11", "irTx in reset", int'(irTx), 0);
    check(txReady == 1'b0, "R11", "txReady in reset", int'(txReady), 0);
    check(rxValid == 1'b0, "R11", "rxValid in reset", int'(rxValid), 0);
    check(!cfgValid && !cfgError, "R8", "status in reset", {cfgValid, cfgError}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(cfgValid && !cfgError, "R8", "status for supported word", {cfgValid, cfgError}, 2);

    // R1 R2 R3 R5: fastest rate, several patterns
    sendByte(8'hA5, "R1 R2 R3");
    sendByte(8'h00, "R2 R3");
    sendByte(8'hFF, "R3");
    // R10: preamble field set, waveform unchanged
    setCfg(0, 3, 17);
    sendByte(8'h3C, "R10");
    // R1: other rates and pulse widths
    setCfg(1, 7, 0);
    sendByte(8'h5A, "R1 R2");
    setCfg(5, 3, 0);
    sendByte(8'h81, "R1");
    setCfg(11, 3, 0);
    sendByte(8'h7E, "R1");

    // R4 R6: both polarities inverted in loopback
    setCfg(0, 3, 0);
    @(negedge clk);
    invTx = 1'b1; invRx = 1'b1;
    @(negedge clk);
    check(irTx == 1'b1, "R4", "inverted idle level", int'(irTx), 1);
    sendByte(8'hC3, "R4");
    sendByte(8'h18, "R4");
    drain();

    // R6: inverted detector driven directly
    @(negedge clk);
    manualRx = 1'b1; loopEn = 1'b0; invTx = 1'b0;
    sendManual(8'h0F, 1'b0, 1'b1);
    drain();
    @(negedge clk);
    invRx = 1'b0; manualRx = 1'b0;
    repeat (3) @(negedge clk);
    sendManual(8'h96, 1'b0, 1'b1);
    // R7: light in the stop slot, then a clean frame
    sendManual(8'h69, 1'b1, 1'b1);
    sendManual(8'hE7, 1'b0, 1'b1);
    drain();

    // R8 R9: unsupported divisor blocks both directions
    setCfg(3, 3, 0);
    check(cfgError && !cfgValid, "R8", "status for divisor 3", {cfgValid, cfgError}, 1);
    check(txReady == 1'b0, "R9", "ready while unusable", int'(txReady), 0);
    txValid = 1'b1; txData = 8'h00;
    bad = 0;
    for (int n = 0; n < 60; n++) begin
      @(negedge clk);
      if (irTx !== 1'b0 || txReady !== 1'b0) bad++;
    end
    txValid = 1'b0;
    check(bad == 0, "R9", "tx idle cycles while unusable", bad, 0);
    sendManual(8'h55, 1'b0, 1'b0);
    setCfg(0, 0, 0);
    check(cfgError && !cfgValid, "R8", "status for zero pulse code", {cfgValid, cfgError}, 1);
    setCfg(0, 10, 0);
    check(cfgError && !cfgValid, "R8", "status for pulse equal to slot", {cfgValid, cfgError}, 1);
    setCfg(1, 10, 0);
    check(cfgValid && !cfgError, "R8", "status for pulse shorter than slot", {cfgValid, cfgError}, 2);
    @(negedge clk);
    loopEn = 1'b1;
    repeat (3) @(negedge clk);
    sendByte(8'hA9, "R1 R2");
    drain();

    check(txQ.size() == 0 && rxQ.size() == 0, "R5", "all expected items seen",
          txQ.size() + rxQ.size(), 0);
    summary();
    $finish;
  end
endmodule